// File: doc/BRIEF.md
# Shadow RAM to EEPROM Block Controller

This block sits in front of a small non-volatile store organised in 16-byte blocks. Software never writes that store directly. It writes a shadow RAM image. It then issues function commands that move a whole block between the shadow image and the store, or that write-protect a block for good. Each command is an opcode with one address byte. Any address inside a block selects that whole block. A command whose address lies outside the block region does nothing.

A copy moves the selected shadow block into the store. It holds a busy flag for a programmable number of clock cycles, which stands in for the programming time of the cells. While the flag is up, writes to the block region are dropped. Traffic to the general scratch region carries on as usual. A recall loads a store block back into the shadow image in a single cycle. A lock command sets a sticky protect flag for a block, but only when the lock enable input is high. Nothing clears a protect flag except a power-on reset. The storage cells are modelled as registers.

The memory port reads without a clock cycle of delay. Writes take effect at the clock edge. An address that maps to neither region reads FFh.

Top module: `eectl_top`

## Requirements
- R1: The opcodes are 48h for copy, B8h for recall and 6Ah for lock. Any other opcode with cmdValid high changes no state.
- R2: Block k covers addresses EE_BASE+16k to EE_BASE+16k+15, and any address in that range selects block k. A command whose address is below EE_BASE or at or above EE_BASE+16*NUM_BLOCKS changes no state.
- R3: A copy accepted at a clock edge raises busy after that edge. Busy stays high for exactly COPY_CYCLES cycles. After that, the 16 shadow bytes of the block are held in the store, and a later recall shows them.
- R4: A copy addressed to a locked block is ignored: busy stays low and the store is unchanged.
- R5: While busy is high, memory writes to the block region are dropped, and a further copy command is ignored.
- R6: While busy is high, reads and writes to the scratch region (PLAIN_BASE, PLAIN_BYTES bytes) work normally.
- R7: A recall copies the whole store block into the shadow block in one cycle. A recall issued while busy is high is refused.
- R8: A lock with lockEnable=1 sets lockFlags[k] for the selected block k. With lockEnable=0 a lock has no effect.
- R9: A set lock flag never clears. Memory writes to the shadow bytes of a locked block are dropped.
- R10: After reset, busy is 0, all lock flags are 0, and all memory reads 00h. Addresses outside both regions read FFh and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdValid | input | 1 | Decoded command present; sampled when its last address bit is in |
| cmdOp | input | 8 | Function opcode |
| cmdAddr | input | 8 | Address byte that selects the block |
| lockEnable | input | 1 | Lock enable bit; lock commands only act when high |
| memWe | input | 1 | Memory write strobe |
| memAddr | input | 8 | Memory address for read and write |
| memWdata | input | 8 | Memory write data |
| memRdata | output | 8 | Memory read data, combinational from memAddr |
| busy | output | 1 | Copy in progress |
| lockFlags | output | NUM_BLOCKS | One write-protect flag per block |

## Verification
The bench measures the busy window cycle by cycle. A counter that is off by one shows up as a window of 39 or 41 cycles instead of 40. It writes to the shadow image during a copy and reads it back. A design that does not block these writes would show the new byte, and a design that stalls the scratch region would lose its write. It issues a recall and a second copy during busy, and later recalls the untouched block. A design that honoured either command would show changed contents. Locks are tried with the enable bit both low and high, and then followed by a copy and a write to the locked block. A design that ignores the enable bit or the protect flag would set a flag or start a copy that should not happen.

// File: rtl/eectl_pkg.sv
package eectl_pkg;
  localparam logic [7:0] OP_COPY   = 8'h48;
  localparam logic [7:0] OP_RECALL = 8'hB8;
  localparam logic [7:0] OP_LOCK   = 8'h6A;

  // strobes from control to datapath
  typedef struct packed {
    logic       copyCommit;  // write shadow block into store this edge
    logic       recallGo;    // load store block into shadow this edge
    logic [7:0] blk;         // block index for either strobe
  } ee_strobe_t;
endpackage

// File: rtl/eectl_ctrl.sv
module eectl_ctrl
  import eectl_pkg::*;
#(
  parameter int NUM_BLOCKS  = 2,
  parameter int BLOCK_BYTES = 16,
  parameter int EE_BASE     = 32,
  parameter int COPY_CYCLES = 400000
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  cmdValid,
  input  logic [7:0]            cmdOp,
  input  logic [7:0]            cmdAddr,
  input  logic                  lockEnable,
  output logic                  busy,
  output logic [NUM_BLOCKS-1:0] lockFlags,
  output ee_strobe_t            strobes
);
  localparam int EE_BYTES = NUM_BLOCKS * BLOCK_BYTES;
  localparam int CNT_W    = $clog2(COPY_CYCLES + 1);

  logic [7:0]            cmdOff;
  logic [7:0]            selIdx;
  logic                  cmdInEe;
  logic [NUM_BLOCKS-1:0] hit;
  logic                  selLocked;
  logic                  isCopy, isRecall, isLock, copyStart;
  logic [CNT_W-1:0]      cnt;
  logic [7:0]            copyBlk;

  always_comb begin
    cmdOff  = cmdAddr - 8'(EE_BASE);
    cmdInEe = (int'(cmdAddr) >= EE_BASE) && (int'(cmdAddr) < EE_BASE + EE_BYTES);
    selIdx  = 8'(int'(cmdOff) / BLOCK_BYTES);
    for (int i = 0; i < NUM_BLOCKS; i++)
      hit[i] = cmdInEe && ((int'(cmdOff) / BLOCK_BYTES) == i);
    selLocked = |(hit & lockFlags);
    isCopy    = cmdValid && cmdInEe && (cmdOp == OP_COPY);
    isRecall  = cmdValid && cmdInEe && (cmdOp == OP_RECALL);
    isLock    = cmdValid && cmdInEe && (cmdOp == OP_LOCK);
    copyStart = isCopy && !busy && !selLocked;
    strobes.copyCommit = busy && (cnt == '0);
    strobes.recallGo   = isRecall && !busy;
    strobes.blk        = busy ? copyBlk : selIdx;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy      <= 1'b0;
      cnt       <= '0;
      copyBlk   <= '0;
      lockFlags <= '0;
    end else begin
      if (isLock && lockEnable)
        lockFlags <= lockFlags | hit;
      if (copyStart) begin
        busy    <= 1'b1;
        cnt     <= CNT_W'(COPY_CYCLES - 1);
        copyBlk <= selIdx;
      end else if (busy) begin
        if (cnt == '0) busy <= 1'b0;
        else           cnt  <= cnt - 1'b1;
      end
    end
  end

  // independent length counter for the busy window
  logic [CNT_W-1:0] runLen;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     runLen <= '0;
    else if (busy) runLen <= runLen + 1'b1;
    else           runLen <= '0;
  end

  p_busy_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (busy && (runLen < CNT_W'(COPY_CYCLES - 1))) |=> busy);
  p_busy_end_r3: assert property (@(posedge clk) disable iff (!rstN)
    (busy && (runLen == CNT_W'(COPY_CYCLES - 1))) |=> !busy);
  p_locked_copy_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && cmdValid && (cmdOp == OP_COPY) && ((hit & lockFlags) != '0)) |=> !busy);
  p_lock_gated_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(cmdValid && lockEnable && (cmdOp == OP_LOCK)) |=> $stable(lockFlags));
  p_lock_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    (lockFlags != '0) |=> (($past(lockFlags) & ~lockFlags) == '0));
endmodule

// File: rtl/eectl_dpath.sv
module eectl_dpath
  import eectl_pkg::*;
#(
  parameter int NUM_BLOCKS  = 2,
  parameter int BLOCK_BYTES = 16,
  parameter int EE_BASE     = 32,
  parameter int PLAIN_BASE  = 128,
  parameter int PLAIN_BYTES = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ee_strobe_t            strobes,
  input  logic                  busy,
  input  logic [NUM_BLOCKS-1:0] lockFlags,
  input  logic                  memWe,
  input  logic [7:0]            memAddr,
  input  logic [7:0]            memWdata,
  output logic [7:0]            memRdata
);
  localparam int EE_BYTES = NUM_BLOCKS * BLOCK_BYTES;

  logic [EE_BYTES-1:0][7:0]    shadow;
  logic [EE_BYTES-1:0][7:0]    eeStore;
  logic [PLAIN_BYTES-1:0][7:0] plainRam;
  logic [7:0] eeOff, plOff;
  logic       inEe, inPlain, addrLocked, eeWrOk;

  always_comb begin
    eeOff   = memAddr - 8'(EE_BASE);
    plOff   = memAddr - 8'(PLAIN_BASE);
    inEe    = (int'(memAddr) >= EE_BASE) && (int'(memAddr) < EE_BASE + EE_BYTES);
    inPlain = (int'(memAddr) >= PLAIN_BASE) && (int'(memAddr) < PLAIN_BASE + PLAIN_BYTES);
    addrLocked = 1'b0;
    for (int b = 0; b < NUM_BLOCKS; b++)
      if (((int'(eeOff) / BLOCK_BYTES) == b) && lockFlags[b]) addrLocked = 1'b1;
    eeWrOk = memWe && inEe && !busy && !addrLocked;
    memRdata = 8'hFF;
    for (int i = 0; i < EE_BYTES; i++)
      if (inEe && (int'(eeOff) == i)) memRdata = shadow[i];
    for (int i = 0; i < PLAIN_BYTES; i++)
      if (inPlain && (int'(plOff) == i)) memRdata = plainRam[i];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shadow   <= '0;
      eeStore  <= '0;
      plainRam <= '0;
    end else begin
      for (int i = 0; i < EE_BYTES; i++) begin
        if (strobes.recallGo && (int'(strobes.blk) == i / BLOCK_BYTES))
          shadow[i] <= eeStore[i];
        else if (eeWrOk && (int'(eeOff) == i))
          shadow[i] <= memWdata;
        if (strobes.copyCommit && (int'(strobes.blk) == i / BLOCK_BYTES))
          eeStore[i] <= shadow[i];
      end
      for (int i = 0; i < PLAIN_BYTES; i++)
        if (memWe && inPlain && (int'(plOff) == i))
          plainRam[i] <= memWdata;
    end
  end

  p_commit_in_busy_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobes.copyCommit |-> busy);
  p_shadow_frozen_r5: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !strobes.recallGo) |=> $stable(shadow));
  p_recall_idle_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobes.recallGo |-> !busy);
endmodule

// File: rtl/eectl_top.sv
module eectl_top
  import eectl_pkg::*;
#(
  parameter int NUM_BLOCKS  = 2,
  parameter int BLOCK_BYTES = 16,
  parameter int EE_BASE     = 32,
  parameter int PLAIN_BASE  = 128,
  parameter int PLAIN_BYTES = 16,
  parameter int COPY_CYCLES = 400000
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  cmdValid,
  input  logic [7:0]            cmdOp,
  input  logic [7:0]            cmdAddr,
  input  logic                  lockEnable,
  input  logic                  memWe,
  input  logic [7:0]            memAddr,
  input  logic [7:0]            memWdata,
  output logic [7:0]            memRdata,
  output logic                  busy,
  output logic [NUM_BLOCKS-1:0] lockFlags
);
  ee_strobe_t strobes;

  eectl_ctrl #(
    .NUM_BLOCKS(NUM_BLOCKS), .BLOCK_BYTES(BLOCK_BYTES),
    .EE_BASE(EE_BASE), .COPY_CYCLES(COPY_CYCLES)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdAddr(cmdAddr), .lockEnable(lockEnable), .busy(busy),
    .lockFlags(lockFlags), .strobes(strobes)
  );

  eectl_dpath #(
    .NUM_BLOCKS(NUM_BLOCKS), .BLOCK_BYTES(BLOCK_BYTES), .EE_BASE(EE_BASE),
    .PLAIN_BASE(PLAIN_BASE), .PLAIN_BYTES(PLAIN_BYTES)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .busy(busy),
    .lockFlags(lockFlags), .memWe(memWe), .memAddr(memAddr),
    .memWdata(memWdata), .memRdata(memRdata)
  );
endmodule

// File: tb/tb_eectl_top.sv
`timescale 1ns/1ps
module tb_eectl_top;
  localparam int NB = 2;
  localparam int CC = 40;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdValid = 1'b0, lockEnable = 1'b0, memWe = 1'b0;
  logic [7:0] cmdOp = '0, cmdAddr = '0, memAddr = '0, memWdata = '0;
  logic [7:0] memRdata;
  logic busy;
  logic [NB-1:0] lockFlags;

  always #2.5 clk = ~clk;

  eectl_top #(.NUM_BLOCKS(NB), .BLOCK_BYTES(16), .EE_BASE(32),
              .PLAIN_BASE(128), .PLAIN_BYTES(16), .COPY_CYCLES(CC)) dut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdAddr(cmdAddr), .lockEnable(lockEnable), .memWe(memWe),
    .memAddr(memAddr), .memWdata(memWdata), .memRdata(memRdata),
    .busy(busy), .lockFlags(lockFlags)
  );

  typedef struct { int kind; logic [7:0] exp; string req; } item_t;
  item_t q[$];
  int checks = 0, errors = 0;
  bit done = 0;

  // monitor: pops expectations and compares away from the active edge
  always @(negedge clk) begin
    item_t it;
    logic [7:0] act;
    while (q.size() > 0) begin
      it = q.pop_front();
      case (it.kind)
        0:       act = memRdata;
        1:       act = {7'b0, busy};
        default: act = {6'b0, lockFlags};
      endcase
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s: actual %02h expected %02h", it.req, act, it.exp);
      end
    end
  end

  task automatic tick(); @(posedge clk); #1; endtask

  task automatic pushExp(int kind, logic [7:0] exp, string req);
    item_t it;
    it.kind = kind; it.exp = exp; it.req = req;
    q.push_back(it);
  endtask

  task automatic readChk(logic [7:0] a, logic [7:0] exp, string req);
    memAddr = a; pushExp(0, exp, req); tick();
  endtask

  task automatic busyChk(logic exp, string req);
    pushExp(1, {7'b0, exp}, req); tick();
  endtask

  task automatic lockChk(logic [NB-1:0] exp, string req);
    pushExp(2, {6'b0, exp}, req); tick();
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    memWe = 1'b1; memAddr = a; memWdata = d; tick(); memWe = 1'b0;
  endtask

  task automatic cmd(logic [7:0] op, logic [7:0] a, logic en);
    cmdValid = 1'b1; cmdOp = op; cmdAddr = a; lockEnable = en; tick();
    cmdValid = 1'b0; lockEnable = 1'b0;
  endtask

  task automatic waitIdle();
    while (busy) tick();
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected finished");
    finishRun();
  end

  initial begin
    int n;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    tick();
    // R10 reset state and unmapped reads
    busyChk(1'b0, "R10 busy after reset");
    lockChk(2'b00, "R10 locks after reset");
    readChk(8'h20, 8'h00, "R10 shadow after reset");
    readChk(8'h85, 8'h00, "R10 scratch after reset");
    readChk(8'h10, 8'hFF, "R10 unmapped read");

    wr(8'h23, 8'hA5); wr(8'h2F, 8'h5A); wr(8'h30, 8'hC3);
    readChk(8'h23, 8'hA5, "R5 shadow write when idle");

    // R2 any address in block 0 selects it; R3 busy rises
    cmd(8'h48, 8'h2F, 1'b0);
    busyChk(1'b1, "R3 busy after copy");
    wr(8'h23, 8'h00);
    readChk(8'h23, 8'hA5, "R5 write during busy dropped");
    wr(8'h81, 8'h77);
    readChk(8'h81, 8'h77, "R6 scratch write during busy");
    cmd(8'hB8, 8'h30, 1'b0);
    readChk(8'h30, 8'hC3, "R7 recall refused while busy");
    cmd(8'h48, 8'h35, 1'b0);
    waitIdle();

    wr(8'h23, 8'h11);
    readChk(8'h23, 8'h11, "R3 shadow writable after copy");
    cmd(8'hB8, 8'h20, 1'b0);
    readChk(8'h23, 8'hA5, "R3 copied byte recalled");
    readChk(8'h2F, 8'h5A, "R7 whole block recalled");
    cmd(8'hB8, 8'h3A, 1'b0);
    readChk(8'h30, 8'h00, "R5 copy during busy ignored");

    // R1 unknown opcode, R2 out-of-range addresses
    cmd(8'h55, 8'h20, 1'b1);
    busyChk(1'b0, "R1 unknown opcode no busy");
    lockChk(2'b00, "R1 unknown opcode no lock");
    cmd(8'h48, 8'h40, 1'b0);
    busyChk(1'b0, "R2 copy above region ignored");
    cmd(8'h6A, 8'h1F, 1'b1);
    lockChk(2'b00, "R2 lock below region ignored");

    // R8 lock enable gating
    cmd(8'h6A, 8'h31, 1'b0);
    lockChk(2'b00, "R8 lock without enable");
    cmd(8'h6A, 8'h31, 1'b1);
    lockChk(2'b10, "R8 lock with enable");
    wr(8'h31, 8'h99);
    readChk(8'h31, 8'h00, "R9 write to locked block dropped");
    cmd(8'h48, 8'h3F, 1'b0);
    busyChk(1'b0, "R4 copy to locked block ignored");
    cmd(8'h55, 8'h31, 1'b1);
    lockChk(2'b10, "R9 lock flag stays set");

    // R3 exact busy window
    wr(8'h2A, 8'h3C);
    cmd(8'h48, 8'h25, 1'b0);
    n = 0;
    while (busy && n < 1000) begin n++; tick(); end
    checks++;
    if (n != CC) begin
      errors++;
      $display("FAIL R3 busy length: actual %0d expected %0d", n, CC);
    end
    wr(8'h2A, 8'h00);
    cmd(8'hB8, 8'h20, 1'b0);
    readChk(8'h2A, 8'h3C, "R3 second copy committed");
    lockChk(2'b10, "R9 lock flag after copy");

    wr(8'h50, 8'h12);
    readChk(8'h50, 8'hFF, "R10 unmapped write ignored");
    tick();
    finishRun();
  end
endmodule